// File: doc/BRIEF.md
# Real-Time Counter with Dual Alarm Compare

This peripheral keeps time for a system that runs from a 32768 Hz oscillator. A prescaler divides the input clock by a programmable amount and emits a single-cycle tick. Each tick advances a 32-bit free-running counter, which wraps silently back to zero. Two independent compare registers watch the counter. When a match occurs and that compare is enabled, a sticky flag is raised. A periodic tick flag can also be enabled. The interrupt line is asserted while any enabled flag is set.

Software reaches the block through a flat register port, made of an address, a write strobe, write data and a combinational read-data path. The flags and their enables share one status word. A flag is cleared by writing a 1 to its bit. A scratch word is not touched by reset, so it keeps a software-maintained overflow count across a warm reboot. A small clock-source selection field is stored here and read back.

Top module: `rtc_alarm_core`

## Requirements
- R1: Registers sit at byte offsets counter 0x00, alarm A 0x04, status 0x08, divider 0x0C, alarm B 0x18, clock select 0x1C and scratch 0x40. Read data is combinational from the address in the same cycle, and any other offset reads as zero.
- R2: The prescaler produces one tick every 2*(DIV+1) clock cycles. A write to the divider restarts the prescaler count from zero at that clock edge.
- R3: Each tick increments the counter by one, and 0xFFFFFFFF is followed by 0x00000000.
- R4: A write to the counter loads the written value at that edge. The write takes priority over a tick that falls in the same cycle.
- R5: The status word has alarm A flag at bit 0, tick flag at bit 1, alarm A enable at bit 2, tick enable at bit 3, alarm B flag at bit 4 and alarm B enable at bit 6. All other bits read as zero. The enable bits are plain read/write bits.
- R6: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. If the flag's set condition holds in the same cycle, the set wins.
- R7: The alarm A flag becomes 1 one edge after the counter equals alarm A while alarm A enable is 1. A match with the enable at 0 sets nothing.
- R8: The alarm B flag behaves the same way, using alarm B and its own enable.
- R9: When tick enable is 1, every prescaler tick sets the tick flag.
- R10: The interrupt output is high exactly while some flag and its matching enable are both 1.
- R11: The clock-select register stores the low two bits of the written data, and its upper bits read as zero.
- R12: The scratch register is plain 32-bit storage, and reset does not alter it.
- R13: Reset clears the counter, both alarms, the status word, the divider, the clock-select field and the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 7 | Register byte offset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current address |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag clear that collides with its own set condition. The counter normally leaves the matching value after a couple of cycles, so the collision does not last. The bench programs a very long divider, which freezes the counter on the alarm value, and then issues the write-1-to-clear while the match still holds. The tick period is swept across several divider values, counting edges from the divider write. The counter wrap and the write-versus-tick priority are hit by placing a counter write on the exact cycle the prescaler fires.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    // Register byte offsets (software decodes these)
    localparam int unsigned OFS_COUNT  = 'h00;
    localparam int unsigned OFS_CMP_A  = 'h04;
    localparam int unsigned OFS_STATUS = 'h08;
    localparam int unsigned OFS_DIV    = 'h0C;
    localparam int unsigned OFS_CMP_B  = 'h18;
    localparam int unsigned OFS_CLKSEL = 'h1C;
    localparam int unsigned OFS_SCRAT  = 'h40;

    // Status word bit positions
    localparam int unsigned SB_FLAG_A = 0;
    localparam int unsigned SB_FLAG_T = 1;
    localparam int unsigned SB_EN_A   = 2;
    localparam int unsigned SB_EN_T   = 3;
    localparam int unsigned SB_FLAG_B = 4;
    localparam int unsigned SB_EN_B   = 6;

    localparam int unsigned NUM_CMP = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             restart,
    output logic             tick,
    output logic [DIV_W:0]   pre_cnt
);
    localparam int unsigned PC_W = DIV_W + 1;

    logic [PC_W-1:0] pre_d, pre_q;
    logic [PC_W-1:0] limit;

    always_comb begin
        // period of 2*(div+1) cycles: count 0 .. 2*div+1
        limit = {div_val, 1'b1};
        tick  = (pre_q == limit);
        pre_d = pre_q + PC_W'(1);
        if (tick)    pre_d = '0;
        if (restart) pre_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign pre_cnt = pre_q;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int unsigned CNT_W = 32
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] target,
    input  logic             enable,
    output logic             hit
);
    always_comb hit = enable && (count == target);
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    import rtc_alarm_pkg::*;

    localparam int unsigned SEL_W = 2;

    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] cmp_a;
        logic [DATA_W-1:0] cmp_b;
        logic [DIV_W-1:0]  div;
        logic [SEL_W-1:0]  clksel;
        logic              flag_a;
        logic              flag_t;
        logic              flag_b;
        logic              en_a;
        logic              en_t;
        logic              en_b;
    } core_state_t;

    core_state_t s_d, s_q;
    logic [DATA_W-1:0] scrat_d, scrat_q;

    // address decode
    logic sel_count, sel_cmp_a, sel_status, sel_div, sel_cmp_b, sel_clksel, sel_scrat;
    always_comb begin
        sel_count  = (addr == ADDR_W'(OFS_COUNT));
        sel_cmp_a  = (addr == ADDR_W'(OFS_CMP_A));
        sel_status = (addr == ADDR_W'(OFS_STATUS));
        sel_div    = (addr == ADDR_W'(OFS_DIV));
        sel_cmp_b  = (addr == ADDR_W'(OFS_CMP_B));
        sel_clksel = (addr == ADDR_W'(OFS_CLKSEL));
        sel_scrat  = (addr == ADDR_W'(OFS_SCRAT));
    end

    // prescaler
    logic           tick;
    logic [DIV_W:0] pre_cnt;

    rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (s_q.div),
        .restart (wr_en && sel_div),
        .tick    (tick),
        .pre_cnt (pre_cnt)
    );

    // compare units
    logic [DATA_W-1:0] cmp_val [NUM_CMP];
    logic              cmp_en  [NUM_CMP];
    logic              cmp_hit [NUM_CMP];

    always_comb begin
        cmp_val[0] = s_q.cmp_a;
        cmp_val[1] = s_q.cmp_b;
        cmp_en[0]  = s_q.en_a;
        cmp_en[1]  = s_q.en_b;
    end

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        rtc_alarm_cmp #(.CNT_W(DATA_W)) u_cmp (
            .count  (s_q.count),
            .target (cmp_val[g]),
            .enable (cmp_en[g]),
            .hit    (cmp_hit[g])
        );
    end

    // next-state logic
    always_comb begin
        s_d = s_q;

        if (tick)                s_d.count = s_q.count + DATA_W'(1);
        if (wr_en && sel_count)  s_d.count = wr_data;
        if (wr_en && sel_cmp_a)  s_d.cmp_a = wr_data;
        if (wr_en && sel_cmp_b)  s_d.cmp_b = wr_data;
        if (wr_en && sel_div)    s_d.div   = wr_data[DIV_W-1:0];
        if (wr_en && sel_clksel) s_d.clksel = wr_data[SEL_W-1:0];

        if (wr_en && sel_status) begin
            s_d.en_a = wr_data[SB_EN_A];
            s_d.en_t = wr_data[SB_EN_T];
            s_d.en_b = wr_data[SB_EN_B];
            if (wr_data[SB_FLAG_A]) s_d.flag_a = 1'b0;
            if (wr_data[SB_FLAG_T]) s_d.flag_t = 1'b0;
            if (wr_data[SB_FLAG_B]) s_d.flag_b = 1'b0;
        end

        // set conditions win over a clear in the same cycle
        if (cmp_hit[0])         s_d.flag_a = 1'b1;
        if (cmp_hit[1])         s_d.flag_b = 1'b1;
        if (tick && s_q.en_t)   s_d.flag_t = 1'b1;

        scrat_d = scrat_q;
        if (wr_en && sel_scrat) scrat_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // scratch storage deliberately has no reset
    always_ff @(posedge clk) begin
        scrat_q <= scrat_d;
    end

    // read path
    logic [DATA_W-1:0] status_word;
    always_comb begin
        status_word            = '0;
        status_word[SB_FLAG_A] = s_q.flag_a;
        status_word[SB_FLAG_T] = s_q.flag_t;
        status_word[SB_EN_A]   = s_q.en_a;
        status_word[SB_EN_T]   = s_q.en_t;
        status_word[SB_FLAG_B] = s_q.flag_b;
        status_word[SB_EN_B]   = s_q.en_b;

        rd_data = '0;
        if (sel_count)  rd_data = s_q.count;
        if (sel_cmp_a)  rd_data = s_q.cmp_a;
        if (sel_status) rd_data = status_word;
        if (sel_div)    rd_data = DATA_W'(s_q.div);
        if (sel_cmp_b)  rd_data = s_q.cmp_b;
        if (sel_clksel) rd_data = DATA_W'(s_q.clksel);
        if (sel_scrat)  rd_data = scrat_q;
    end

    assign irq = (s_q.flag_a && s_q.en_a) || (s_q.flag_t && s_q.en_t) ||
                 (s_q.flag_b && s_q.en_b);

    // named views for the bound checker
    logic [DATA_W-1:0] count_view;
    logic              flag_a_view, en_a_view, hit_a_view;
    assign count_view  = s_q.count;
    assign flag_a_view = s_q.flag_a;
    assign en_a_view   = s_q.en_a;
    assign hit_a_view  = cmp_hit[0];
endmodule

// File: rtl/rtc_alarm_core_chk.sv
module rtc_alarm_core_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] count_q,
    input logic [DIV_W:0]    pre_cnt,
    input logic              hit_a,
    input logic              flag_a,
    input logic              en_a,
    input logic              irq
);
    import rtc_alarm_pkg::*;

    logic wr_cnt, wr_div, wr_stat_clr_a;
    assign wr_cnt        = wr_en && (addr == ADDR_W'(OFS_COUNT));
    assign wr_div        = wr_en && (addr == ADDR_W'(OFS_DIV));
    assign wr_stat_clr_a = wr_en && (addr == ADDR_W'(OFS_STATUS)) && wr_data[SB_FLAG_A];

    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_div |=> (pre_cnt == '0));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt |=> ((count_q == $past(count_q)) || (count_q == $past(count_q) + DATA_W'(1))));

    p_count_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (count_q == $past(wr_data)));

    p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat_clr_a && !hit_a) |=> !flag_a);

    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a && !wr_stat_clr_a) |=> flag_a);

    p_alarm_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> flag_a);

    p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a && en_a) |-> irq);
endmodule

bind rtc_alarm_core rtc_alarm_core_chk #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .count_q (count_view),
    .pre_cnt (pre_cnt),
    .hit_a   (hit_a_view),
    .flag_a  (flag_a_view),
    .en_a    (en_a_view),
    .irq     (irq)
);

// File: tb/rtc_alarm_core_bench.sv
module rtc_alarm_core_bench;
    localparam logic [6:0] A_CNT = 7'h00, A_AL0 = 7'h04, A_ST = 7'h08, A_DIV = 7'h0C,
                           A_AL1 = 7'h18, A_CSW = 7'h1C, A_SCR = 7'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    rtc_alarm_core u_rtc_alarm_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_cleared(input string tag);
        logic [31:0] v;
        rd(A_CNT, v); chk({tag, " R13 counter"}, v, 32'h0);
        rd(A_AL0, v); chk({tag, " R13 alarm A"}, v, 32'h0);
        rd(A_AL1, v); chk({tag, " R13 alarm B"}, v, 32'h0);
        rd(A_ST,  v); chk({tag, " R13 status"}, v, 32'h0);
        rd(A_DIV, v); chk({tag, " R13 divider"}, v, 32'h0);
        rd(A_CSW, v); chk({tag, " R13 clock select"}, v, 32'h0);
        chk({tag, " R13 irq"}, {31'h0, irq}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v, c0, c;
        @(negedge clk);
        do_reset();
        check_cleared("reset");

        // R2/R3: tick period sweep
        for (int d = 0; d <= 5; d++) begin
            wr(A_DIV, d);
            rd(A_CNT, c0);
            for (int k = 1; k <= 3 * (2 * d + 2); k++) begin
                @(negedge clk);
                rd(A_CNT, v);
                chk($sformatf("R2 R3 period div=%0d k=%0d", d, k), v,
                    c0 + 32'(k / (2 * d + 2)));
            end
        end

        // R3: wrap
        wr(A_DIV, 0);
        wr(A_CNT, 32'hFFFF_FFFE);
        rd(A_CNT, v); chk("R4 load", v, 32'hFFFF_FFFE);
        @(negedge clk); rd(A_CNT, v); chk("R3 pre-wrap", v, 32'hFFFF_FFFF);
        @(negedge clk); @(negedge clk); rd(A_CNT, v); chk("R3 wrap to zero", v, 32'h0);

        // R4: write coinciding with a tick wins
        wr(A_DIV, 0);
        @(negedge clk);
        wr(A_CNT, 32'h100);
        rd(A_CNT, v); chk("R4 write beats tick", v, 32'h100);
        @(negedge clk); rd(A_CNT, v); chk("R4 hold", v, 32'h100);
        @(negedge clk); rd(A_CNT, v); chk("R4 next tick", v, 32'h101);

        // R7: alarm A
        wr(A_AL0, 13);
        wr(A_ST, 32'h04);
        wr(A_CNT, 10);
        for (int i = 0; i < 40; i++) begin
            rd(A_CNT, v);
            if (v == 13) break;
            @(negedge clk);
        end
        rd(A_ST, v); chk("R7 flag not before edge", v & 32'h1, 32'h0);
        @(negedge clk);
        rd(A_ST, v); chk("R7 flag A set", v & 32'h1, 32'h1);
        chk("R8 flag B quiet when disabled", v & 32'h10, 32'h0);
        chk("R10 irq from alarm A", {31'h0, irq}, 32'h1);
        repeat (4) @(negedge clk);
        wr(A_ST, 32'h04);
        rd(A_ST, v); chk("R6 write 0 keeps flag", v & 32'h1, 32'h1);
        wr(A_ST, 32'h05);
        rd(A_ST, v); chk("R6 write 1 clears flag", v, 32'h04);
        chk("R10 irq drops", {31'h0, irq}, 32'h0);

        // R8: alarm B
        rd(A_CNT, c);
        wr(A_AL1, c + 6);
        wr(A_ST, 32'h40);
        for (int i = 0; i < 40; i++) begin
            rd(A_CNT, v);
            if (v == c + 6) break;
            @(negedge clk);
        end
        @(negedge clk);
        rd(A_ST, v); chk("R8 flag B set", v, 32'h50);
        chk("R10 irq from alarm B", {31'h0, irq}, 32'h1);
        repeat (4) @(negedge clk);
        wr(A_ST, 32'h50);
        rd(A_ST, v); chk("R8 flag B cleared", v, 32'h40);

        // R6: set wins over clear while match persists
        wr(A_DIV, 1000);
        wr(A_CNT, 32'h55);
        wr(A_AL0, 32'h55);
        wr(A_ST, 32'h04);
        @(negedge clk);
        rd(A_ST, v); chk("R7 frozen match sets", v & 32'h1, 32'h1);
        wr(A_ST, 32'h05);
        rd(A_ST, v); chk("R6 set wins over clear", v & 32'h1, 32'h1);
        wr(A_ST, 32'h00);
        wr(A_ST, 32'h01);
        @(negedge clk);
        rd(A_ST, v); chk("R7 disabled match sets nothing", v & 32'h1, 32'h0);

        // R9: tick flag
        wr(A_DIV, 0);
        wr(A_ST, 32'h08);
        repeat (3) @(negedge clk);
        rd(A_ST, v); chk("R9 tick flag set", v & 32'h2, 32'h2);
        chk("R10 irq from tick", {31'h0, irq}, 32'h1);
        wr(A_DIV, 100);
        wr(A_ST, 32'h0A);
        rd(A_ST, v); chk("R9 tick flag cleared", v & 32'h2, 32'h0);
        repeat (190) @(negedge clk);
        rd(A_ST, v); chk("R2 R9 no tick before period", v & 32'h2, 32'h0);
        repeat (20) @(negedge clk);
        rd(A_ST, v); chk("R2 R9 tick after period", v & 32'h2, 32'h2);
        wr(A_ST, 32'h02);
        chk("R10 irq off with enables off", {31'h0, irq}, 32'h0);

        // R5: status layout
        wr(A_DIV, 1000);
        wr(A_AL0, 32'hDEAD);
        wr(A_AL1, 32'hBEEF);
        wr(A_CNT, 0);
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, v); chk("R5 only enable bits stick", v, 32'h4C);
        wr(A_ST, 32'h0);
        rd(A_ST, v); chk("R5 enables read/write", v, 32'h0);

        // R1: map and unmapped reads
        rd(A_AL0, v); chk("R1 alarm A readback", v, 32'hDEAD);
        rd(A_AL1, v); chk("R1 alarm B readback", v, 32'hBEEF);
        rd(A_DIV, v); chk("R1 divider readback", v, 32'd1000);
        rd(7'h20, v); chk("R1 unmapped 0x20", v, 32'h0);
        rd(7'h44, v); chk("R1 unmapped 0x44", v, 32'h0);

        // R11: clock select
        wr(A_CSW, 32'hFFFF_FFFF);
        rd(A_CSW, v); chk("R11 two-bit field", v, 32'h3);
        wr(A_CSW, 32'h1);
        rd(A_CSW, v); chk("R11 readback", v, 32'h1);
        wr(A_CSW, 32'h3);

        // R12/R13: scratch survives reset
        wr(A_SCR, 32'hCAFE_F00D);
        rd(A_SCR, v); chk("R12 scratch write", v, 32'hCAFE_F00D);
        do_reset();
        rd(A_SCR, v); chk("R12 scratch kept over reset", v, 32'hCAFE_F00D);
        check_cleared("second reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule